// File: doc/BRIEF.md
# Quadrature Output Formatter and Serializer

This block sits between a sine/cosine sample source and the output pins of an oscillator. Each clock it accepts a 16-bit two's complement sine sample, a 16-bit two's complement cosine sample and a 28-bit phase word. It drives two 16-bit output buses. A format control picks between two's complement and offset binary. A mode control picks between parallel words and bit-serial streams. A diagnostic control replaces the samples with the phase word.

In serial mode every bus carries two streams of the same word at once. The top bit shifts the word out most significant bit first and fills with zeros once the word is used up. The bottom bit shifts it out least significant bit first and fills with copies of the sign bit. A word is captured while the registered active-low accumulator enable is low, and shifting starts once that enable goes high again. An active-low strobe marks the cycle in which the first bit of a fresh word sits at the outputs. The per-bus active-low output enables are passed through as active-high valid flags.

All control and data inputs are first captured in one register stage. The output registers load from that stage on the next edge, so every input reaches the outputs after exactly two rising edges.

Top module: `quad_out_shaper`

## Requirements
- R1: After a synchronous active-low reset, both buses read 0x0000, the strobe is high and the block is in parallel mode with two's complement format.
- R2: Every data and control input is registered once before use, so a change applied before rising edge k shows at the outputs after rising edge k+1.
- R3: With the registered format input low, bit 15 of each sample word is inverted (offset binary). With it high, the word passes unchanged.
- R4: With the registered mode input high (parallel), each bus takes a new formatted sample on every clock and no shifting takes place.
- R5: With the mode input low (serial), a word is loaded on every edge at which the registered accumulator enable is low. On each later edge with that enable high, the word moves one bit, so bus bit 15 presents word bits 15, 14, ..., 0 on successive cycles.
- R6: On bus bit 15, once all 16 bits of a serial word have appeared and no new word has been loaded, the value is 0.
- R7: Bus bit 0 presents word bits 0, 1, ..., 15 on successive cycles after a serial load, then keeps repeating the word's bit 15 until the next load.
- R8: The strobe is low exactly in the cycle after a serial load edge, which is when the first bit of the new word is visible. It is high in every other cycle and always high in parallel mode.
- R9: In serial mode, bus bits 14 down to 1 read 0.
- R10: With the registered diagnostic and mode inputs both high, the sine bus shows phase bits 27:12, cosine bits 15:4 show phase bits 11:0 and cosine bits 3:0 read 0. No format inversion is applied.
- R11: In serial mode the diagnostic input has no effect: the streams carry the formatted samples.
- R12: Each valid flag is high exactly while its active-low output enable input is low, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sin_in | input | 16 | Sine sample, two's complement |
| cos_in | input | 16 | Cosine sample, two's complement |
| phase_in | input | 28 | Phase word for the diagnostic view |
| acc_en_n | input | 1 | Accumulator enable, active low; loads serial words |
| twos_fmt | input | 1 | 1 = two's complement, 0 = offset binary |
| par_mode | input | 1 | 1 = parallel words, 0 = serial streams |
| diag_mode | input | 1 | 1 = show phase word (parallel mode only) |
| sin_oe_n | input | 1 | Sine bus enable, active low |
| cos_oe_n | input | 1 | Cosine bus enable, active low |
| sin_out | output | 16 | Sine bus |
| cos_out | output | 16 | Cosine bus |
| word_strb_n | output | 1 | First-bit strobe, active low |
| sin_vld | output | 1 | Sine bus valid |
| cos_vld | output | 1 | Cosine bus valid |

## Verification
Parallel runs with random samples, in both formats, show whether bit 15 alone is inverted and whether a new word lands on every clock. Serial runs that load once every 16 cycles, and runs that load at random gaps of up to 24 cycles, show the two stream orders and the zero and sign fill that follow a used-up word. They also catch a strobe that comes a cycle early or late. Diagnostic runs in both modes show the phase slicing in parallel mode and the absence of any effect in serial mode. A directed step checks the two-edge latency on its own.

// File: rtl/qfs_pkg.sv
// Package: shared control bundle for the quadrature output shaper.
// Assumes all fields are already registered where they are consumed.
package qfs_pkg;

    // Registered control pins, one bit each.
    typedef struct packed {
        logic acc_en_n;  // low = load serial word
        logic twos;      // high = two's complement
        logic par;       // high = parallel mode
        logic diag;      // high = phase view (with par)
    } qfs_ctl_t;

    localparam qfs_ctl_t QFS_CTL_RST = '{acc_en_n: 1'b1, twos: 1'b1, par: 1'b1, diag: 1'b0};

endpackage

// File: rtl/qfs_in_stage.sv
// Module: input capture stage.
// Registers every control and data pin once, so downstream logic sees
// a coherent set of values. Assumes a synchronous active-low reset.
module qfs_in_stage
    import qfs_pkg::*;
#(
    parameter int SW = 16,
    parameter int PW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sin_d,
    input  logic [SW-1:0] cos_d,
    input  logic [PW-1:0] ph_d,
    input  qfs_ctl_t      ctl_d,
    output logic [SW-1:0] sin_q,
    output logic [SW-1:0] cos_q,
    output logic [PW-1:0] ph_q,
    output qfs_ctl_t      ctl_q
);

    // Capture all pins on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_q <= '0;
            cos_q <= '0;
            ph_q  <= '0;
            ctl_q <= QFS_CTL_RST;
        end else begin
            sin_q <= sin_d;
            cos_q <= cos_d;
            ph_q  <= ph_d;
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/qfs_word_sel.sv
// Module: word selection and format.
// Builds the word each lane loads: the formatted sample, or the phase
// slice when the diagnostic view is active in parallel mode.
// Assumes PW > SW and PW < 2*SW.
module qfs_word_sel
    import qfs_pkg::*;
#(
    parameter int SW = 16,
    parameter int PW = 28
) (
    input  logic [SW-1:0]         sin_w,
    input  logic [SW-1:0]         cos_w,
    input  logic [PW-1:0]         ph_w,
    input  qfs_ctl_t              ctl,
    output logic [1:0][SW-1:0]    word
);

    localparam int LOW_W = PW - SW;   // phase bits shown on cosine
    localparam int PAD_W = SW - LOW_W; // zero bits under them

    logic [1:0][SW-1:0] samp;
    logic [1:0][SW-1:0] diag_w;
    logic               use_diag;

    assign samp[0]   = sin_w;
    assign samp[1]   = cos_w;
    assign diag_w[0] = ph_w[PW-1:LOW_W];
    assign diag_w[1] = {ph_w[LOW_W-1:0], {PAD_W{1'b0}}};
    assign use_diag  = ctl.par & ctl.diag;

    // One selector per lane; sign bit flipped for offset binary.
    for (genvar g = 0; g < 2; g++) begin : g_lane_word
        always_comb begin
            if (use_diag) begin
                word[g] = diag_w[g];
            end else begin
                word[g] = {samp[g][SW-1] ^ ~ctl.twos, samp[g][SW-2:0]};
            end
        end
    end

endmodule

// File: rtl/qfs_lane.sv
// Module: one output lane (sine or cosine).
// Holds a left-shifting register feeding the MSB-first stream and a
// right-shifting register feeding the LSB-first stream. In parallel
// mode both load every clock and the bus shows the whole word.
// Assumes out_par is aligned with the register contents.
module qfs_lane #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] word,
    input  logic          ld,
    input  logic          out_par,
    output logic [SW-1:0] bus
);

    logic [SW-1:0] msb_q;
    logic [SW-1:0] lsb_q;

    // Load a new word, or shift: zeros in from the bottom, sign at top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q <= '0;
            lsb_q <= '0;
        end else if (ld) begin
            msb_q <= word;
            lsb_q <= word;
        end else begin
            msb_q <= {msb_q[SW-2:0], 1'b0};
            lsb_q <= {lsb_q[SW-1], lsb_q[SW-1:1]};
        end
    end

    // Bus view: whole word, or the two stream taps with a zero middle.
    always_comb begin
        if (out_par) begin
            bus = msb_q;
        end else begin
            bus = {msb_q[SW-1], {(SW-2){1'b0}}, lsb_q[0]};
        end
    end

    // R5: a load edge places the selected word in both registers
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (msb_q == $past(word)) && (lsb_q == $past(word)));

    // R6: without a load the MSB-first register moves up and fills with zero
    p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (msb_q[0] == 1'b0) && (msb_q[SW-1:1] == $past(msb_q[SW-2:0])));

    // R7: without a load the LSB-first register keeps its sign bit
    p_sign_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (lsb_q[SW-1] == $past(lsb_q[SW-1])) && (lsb_q[SW-2:0] == $past(lsb_q[SW-1:1])));

endmodule

// File: rtl/quad_out_shaper.sv
// Module: quadrature output formatter and serializer (top).
// Registers the pins, selects and formats the words, drives two lanes
// and the first-bit strobe. Output enables become valid flags.
// Assumes one clock domain and a synchronous active-low reset.
module quad_out_shaper
    import qfs_pkg::*;
#(
    parameter int SW = 16,
    parameter int PW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sin_in,
    input  logic [SW-1:0] cos_in,
    input  logic [PW-1:0] phase_in,
    input  logic          acc_en_n,
    input  logic          twos_fmt,
    input  logic          par_mode,
    input  logic          diag_mode,
    input  logic          sin_oe_n,
    input  logic          cos_oe_n,
    output logic [SW-1:0] sin_out,
    output logic [SW-1:0] cos_out,
    output logic          word_strb_n,
    output logic          sin_vld,
    output logic          cos_vld
);

    qfs_ctl_t           ctl_d;
    qfs_ctl_t           ctl_r;
    logic [SW-1:0]      sin_r;
    logic [SW-1:0]      cos_r;
    logic [PW-1:0]      ph_r;
    logic [1:0][SW-1:0] word;
    logic [1:0][SW-1:0] bus;
    logic               ld;
    logic               out_par;

    assign ctl_d = '{acc_en_n: acc_en_n, twos: twos_fmt, par: par_mode, diag: diag_mode};

    qfs_in_stage #(.SW(SW), .PW(PW)) u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .sin_d (sin_in),
        .cos_d (cos_in),
        .ph_d  (phase_in),
        .ctl_d (ctl_d),
        .sin_q (sin_r),
        .cos_q (cos_r),
        .ph_q  (ph_r),
        .ctl_q (ctl_r)
    );

    qfs_word_sel #(.SW(SW), .PW(PW)) u_sel (
        .sin_w (sin_r),
        .cos_w (cos_r),
        .ph_w  (ph_r),
        .ctl   (ctl_r),
        .word  (word)
    );

    // Parallel mode loads every clock; serial only on a low enable.
    assign ld = ctl_r.par | ~ctl_r.acc_en_n;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        qfs_lane #(.SW(SW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .word    (word[g]),
            .ld      (ld),
            .out_par (out_par),
            .bus     (bus[g])
        );
    end

    // Track the mode of the lane contents and mark fresh serial words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_par     <= 1'b1;
            word_strb_n <= 1'b1;
        end else begin
            out_par     <= ctl_r.par;
            word_strb_n <= ctl_r.par | ctl_r.acc_en_n;
        end
    end

    assign sin_out = bus[0];
    assign cos_out = bus[1];
    assign sin_vld = ~sin_oe_n;
    assign cos_vld = ~cos_oe_n;

    // R8: the strobe never drops while the lanes hold parallel data
    p_strobe_par_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_par |-> word_strb_n);

    // R8: a serial load edge is followed by a low strobe
    p_strobe_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_r.par && !ctl_r.acc_en_n) |=> !word_strb_n);

    // R9: the middle bits stay zero in serial mode
    p_mid_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_par |-> (sin_out[SW-2:1] == '0) && (cos_out[SW-2:1] == '0));

    // R4: in parallel mode the bus follows the captured sample in the next cycle
    p_par_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_r.par && !ctl_r.diag) |=> (sin_out[SW-2:0] == $past(sin_r[SW-2:0])));

endmodule

// File: tb/sim_quad_out_shaper.sv
module sim_quad_out_shaper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sin_in = '0, cos_in = '0;
    logic [27:0] phase_in = '0;
    logic        acc_en_n = 1'b1, twos_fmt = 1'b1, par_mode = 1'b1, diag_mode = 1'b0;
    logic        sin_oe_n = 1'b0, cos_oe_n = 1'b0;
    logic [15:0] sin_out, cos_out;
    logic        word_strb_n, sin_vld, cos_vld;

    int vec = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    quad_out_shaper u0 (
        .clk(clk), .rst_n(rst_n), .sin_in(sin_in), .cos_in(cos_in),
        .phase_in(phase_in), .acc_en_n(acc_en_n), .twos_fmt(twos_fmt),
        .par_mode(par_mode), .diag_mode(diag_mode), .sin_oe_n(sin_oe_n),
        .cos_oe_n(cos_oe_n), .sin_out(sin_out), .cos_out(cos_out),
        .word_strb_n(word_strb_n), .sin_vld(sin_vld), .cos_vld(cos_vld)
    );

    // Reference state built from the requirements.
    logic [15:0] s1_sin, s1_cos;
    logic [27:0] s1_ph;
    logic        s1_en, s1_fmt, s1_par, s1_diag;
    logic [15:0] m_msb [2];
    logic [15:0] m_lsb [2];
    logic        m_par, m_stb, m_diag, m_fmt;
    int          m_cnt;

    function automatic logic [15:0] fmt_word(input logic [15:0] w, input logic twos);
        return {w[15] ^ ~twos, w[14:0]};
    endfunction

    function automatic logic [15:0] pick(input int lane);
        if (s1_par && s1_diag)
            return (lane == 0) ? s1_ph[27:12] : {s1_ph[11:0], 4'b0000};
        return fmt_word((lane == 0) ? s1_sin : s1_cos, s1_fmt);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            s1_sin = '0; s1_cos = '0; s1_ph = '0;
            s1_en = 1; s1_fmt = 1; s1_par = 1; s1_diag = 0;
            for (int i = 0; i < 2; i++) begin m_msb[i] = '0; m_lsb[i] = '0; end
            m_par = 1; m_stb = 1; m_diag = 0; m_fmt = 1; m_cnt = 0;
        end else begin
            logic ld;
            ld = s1_par | ~s1_en;
            for (int i = 0; i < 2; i++) begin
                if (ld) begin
                    m_msb[i] = pick(i);
                    m_lsb[i] = pick(i);
                end else begin
                    m_msb[i] = {m_msb[i][14:0], 1'b0};
                    m_lsb[i] = {m_lsb[i][15], m_lsb[i][15:1]};
                end
            end
            m_cnt  = ld ? 0 : m_cnt + 1;
            m_par  = s1_par;
            m_stb  = s1_par | s1_en;
            m_diag = s1_diag;
            m_fmt  = s1_fmt;
            s1_sin = sin_in; s1_cos = cos_in; s1_ph = phase_in;
            s1_en = acc_en_n; s1_fmt = twos_fmt; s1_par = par_mode; s1_diag = diag_mode;
        end
    endtask

    task automatic check_all();
        logic [15:0] act [2];
        act[0] = sin_out;
        act[1] = cos_out;
        chk("R12", {14'b0, sin_vld, cos_vld}, {14'b0, ~sin_oe_n, ~cos_oe_n});
        chk("R8", {15'b0, word_strb_n}, {15'b0, m_stb});
        for (int i = 0; i < 2; i++) begin
            if (m_par) begin
                if (m_diag)      chk("R10", act[i], m_msb[i]);
                else if (!m_fmt) chk("R3", act[i], m_msb[i]);
                else             chk("R4", act[i], m_msb[i]);
            end else begin
                if (m_diag)           chk("R11", act[i], {m_msb[i][15], 14'b0, m_lsb[i][0]});
                if (m_cnt >= 16)      chk("R6", {15'b0, act[i][15]}, 16'h0000);
                else                  chk("R5", {15'b0, act[i][15]}, {15'b0, m_msb[i][15]});
                chk("R7", {15'b0, act[i][0]}, {15'b0, m_lsb[i][0]});
                chk("R9", {2'b0, act[i][14:1]}, 16'h0000);
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rst_n) check_all();
    endtask

    task automatic rand_data();
        sin_in   = 16'($urandom);
        cos_in   = 16'($urandom);
        phase_in = 28'($urandom);
        sin_oe_n = 1'($urandom);
        cos_oe_n = 1'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Reset
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state at the ports
        chk("R1", sin_out, 16'h0000);
        chk("R1", cos_out, 16'h0000);
        chk("R1", {15'b0, word_strb_n}, 16'h0001);

        // R2: two-edge latency in parallel mode
        sin_in = 16'h1234;
        step();
        chk("R2", sin_out, 16'h0000);
        step();
        chk("R2", sin_out, 16'h1234);

        // R3 corner: offset binary of the extremes
        twos_fmt = 1'b0; sin_in = 16'h8001; cos_in = 16'h7FFF;
        step(); step();
        chk("R3", sin_out, 16'h0001);
        chk("R3", cos_out, 16'hFFFF);

        // R10: phase slices in parallel diagnostic view
        diag_mode = 1'b1; phase_in = 28'hABCDEF1;
        step(); step();
        chk("R10", sin_out, 16'hABCD);
        chk("R10", cos_out, 16'hEF10);
        diag_mode = 1'b0;

        // Random parallel runs, both formats
        for (int k = 0; k < 400; k++) begin
            rand_data();
            twos_fmt  = 1'($urandom);
            diag_mode = ($urandom % 4) == 0;
            step();
        end

        // Serial: one load every 16 cycles, negative word for sign fill
        par_mode = 1'b0; diag_mode = 1'b0; twos_fmt = 1'b1;
        for (int w = 0; w < 30; w++) begin
            for (int b = 0; b < 16; b++) begin
                acc_en_n = (b != 0);
                rand_data();
                if (w == 0) begin sin_in = 16'hA5C3; cos_in = 16'h3C5A; end
                step();
            end
        end
        // Long idle to reach both fill states
        acc_en_n = 1'b1;
        repeat (24) step();

        // Serial with random gaps, formats and ignored diagnostic input
        for (int w = 0; w < 80; w++) begin
            int gap;
            gap = 1 + ($urandom % 24);
            twos_fmt  = 1'($urandom);
            diag_mode = 1'($urandom);
            for (int b = 0; b < gap; b++) begin
                acc_en_n = (b != 0);
                rand_data();
                step();
            end
        end

        // Back-to-back serial loads, then mode switches
        acc_en_n = 1'b0;
        repeat (8) begin rand_data(); step(); end
        for (int k = 0; k < 300; k++) begin
            rand_data();
            par_mode  = ($urandom % 8) == 0;
            acc_en_n  = ($urandom % 6) != 0;
            twos_fmt  = 1'($urandom);
            diag_mode = 1'($urandom);
            step();
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule